// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block walks through one memory-mapped read or write burst on a byte-addressed bus. A command handshake hands it a start address, a beat count minus one, a size code and a burst type. From the cycle after acceptance, it presents the address of the current beat, the byte lanes that beat occupies and a flag on the final beat. On each completed data handshake it moves to the next beat.

The block supports three burst types. The address can stay fixed, it can increase by the beat size, or it can increase and fold back inside an aligned wrap window. Narrow beats and an unaligned first beat only enable the byte lanes the beat actually covers. A read or write channel controller places the block beside its data path and uses its outputs for the memory address and the write strobes or read lane selects. Only one burst is in flight at a time.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset the block is idle: `busy_o` and `beat_last_o` are low, `cmd_ready_o` is high and `beat_strb_o` is zero.
- R2: A command is accepted only when `cmd_valid_i` and `cmd_ready_o` are both high, and `cmd_ready_o` is high exactly when the block is idle. A command offered during a burst does not change that burst. A data handshake while idle has no effect.
- R3: Burst type code 0 (fixed) presents the start address on every beat.
- R4: Burst type code 1 (incrementing) presents the start address on beat 0. Beat n>0 is at the start address rounded down to a multiple of 2^size, plus n·2^size.
- R5: Burst type code 2 (wrapping) uses length codes 1, 3, 7 or 15 and a start address aligned to 2^size. Each beat is 2^size above the previous one. An address that reaches the top of the window of (len+1)·2^size bytes containing the start returns to the window's base.
- R6: `beat_strb_o` bit i stands for byte lane i. During a burst the bits set run from lane (address mod bus bytes) up to the last lane of the 2^size-aligned window holding that address, and no other bit is set. This covers narrow and unaligned beats.
- R7: A burst has len+1 beats, up to 256. `beat_last_o` is high only on beat len. The block goes idle on the cycle after that beat's handshake.
- R8: While `beat_valid_i` and `beat_ready_i` are not both high, the address, lane mask and last flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle and able to take a command |
| cmd_addr_i | input | ADDR_W | Start byte address |
| cmd_len_i | input | 8 | Beat count minus one |
| cmd_size_i | input | 3 | Bytes per beat as log2 |
| cmd_burst_i | input | 2 | 0 fixed, 1 incrementing, 2 wrapping |
| beat_valid_i | input | 1 | Data valid on the data channel |
| beat_ready_i | input | 1 | Data ready on the data channel |
| busy_o | output | 1 | Burst in progress |
| beat_addr_o | output | ADDR_W | Address of the current beat |
| beat_strb_o | output | DATA_W/8 | Active byte lanes of the current beat |
| beat_last_o | output | 1 | Current beat is the final one |

## Verification
Directed bursts cover several cases. One is an unaligned narrow fixed burst, where the address must never move. Another is an unaligned incrementing burst, whose first beat is partial and whose later beats snap to alignment. Others include a byte-sized burst whose single lane rotates across the bus, wrap bursts that start mid-window and must fold back to the window base, and a 256-beat full-width burst that exercises the longest count. Random bursts mix all three types, every legal size and random handshake stalls. During stalls, stray commands are offered to show that in-flight state is untouched. Data handshakes are also offered while idle to show they are ignored.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_e;

  localparam int unsigned SIZE_W = 3;
  localparam int unsigned LEN_W  = 8;
endpackage

// File: rtl/burst_step.sv
module burst_step
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  burst_e            burst_i,
  input  logic [ADDR_W-1:0] wrap_mask_i,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  logic [ADDR_W-1:0] bytes, aligned, incr, wrapped;

  always_comb begin
    bytes   = ADDR_W'(1) << size_i;
    aligned = cur_addr_i & ~(bytes - ADDR_W'(1));
    incr    = aligned + bytes;
    // keep the bits above the window, take the low part of the increment
    wrapped = (cur_addr_i & ~wrap_mask_i) | (incr & wrap_mask_i);
    unique case (burst_i)
      BURST_FIXED: nxt_addr_o = cur_addr_i;
      BURST_WRAP:  nxt_addr_o = wrapped;
      default:     nxt_addr_o = incr;
    endcase
  end
endmodule

// File: rtl/burst_lanes.sv
module burst_lanes
  import burst_pkg::*;
#(
  parameter int unsigned STRB_W = 8,
  localparam int unsigned OFF_W = $clog2(STRB_W)
) (
  input  logic              en_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [STRB_W-1:0] strb_o
);
  logic [OFF_W:0] bytes, lo, base, hi_x;

  always_comb begin
    bytes = (OFF_W+1)'(1) << size_i;
    lo    = {1'b0, off_i};
    base  = lo & ~(bytes - (OFF_W+1)'(1));
    hi_x  = base + bytes;
  end

  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    localparam logic [OFF_W:0] LaneIdx = (OFF_W+1)'(i);
    assign strb_o[i] = en_i && (LaneIdx >= lo) && (LaneIdx < hi_x);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned STRB_W = DATA_W / 8,
  localparam int unsigned OFF_W  = $clog2(STRB_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [SIZE_W-1:0] cmd_size_i,
  input  logic [1:0]        cmd_burst_i,
  input  logic              beat_valid_i,
  input  logic              beat_ready_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [STRB_W-1:0] beat_strb_o,
  output logic              beat_last_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q, wmask_q, nxt_addr;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [SIZE_W-1:0] size_q;
  burst_e            burst_q;
  logic              accept, step, last;

  assign accept = cmd_valid_i && !busy_q;
  assign step   = busy_q && beat_valid_i && beat_ready_i;
  assign last   = busy_q && (cnt_q == len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      addr_q  <= '0;
      wmask_q <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      size_q  <= '0;
      burst_q <= BURST_FIXED;
    end else if (accept) begin
      busy_q  <= 1'b1;
      addr_q  <= cmd_addr_i;
      len_q   <= cmd_len_i;
      cnt_q   <= '0;
      size_q  <= cmd_size_i;
      burst_q <= burst_e'(cmd_burst_i);
      // window bytes minus one; meaningful only for wrapping bursts
      wmask_q <= ((ADDR_W'(cmd_len_i) + ADDR_W'(1)) << cmd_size_i) - ADDR_W'(1);
    end else if (step) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        addr_q <= nxt_addr;
        cnt_q  <= cnt_q + LEN_W'(1);
      end
    end
  end

  burst_step #(.ADDR_W(ADDR_W)) u_step (
    .cur_addr_i (addr_q),
    .size_i     (size_q),
    .burst_i    (burst_q),
    .wrap_mask_i(wmask_q),
    .nxt_addr_o (nxt_addr)
  );

  burst_lanes #(.STRB_W(STRB_W)) u_lanes (
    .en_i  (busy_q),
    .off_i (addr_q[OFF_W-1:0]),
    .size_i(size_q),
    .strb_o(beat_strb_o)
  );

  assign cmd_ready_o = !busy_q;
  assign busy_o      = busy_q;
  assign beat_addr_o = addr_q;
  assign beat_last_o = last;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STRB_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cmd_ready_o,
  input logic [SIZE_W-1:0] cmd_size_i,
  input logic [1:0]        cmd_burst_i,
  input logic              beat_valid_i,
  input logic              beat_ready_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] beat_addr_o,
  input logic [STRB_W-1:0] beat_strb_o,
  input logic              beat_last_o
);
  logic [SIZE_W-1:0] sz_q;
  logic [1:0]        bt_q;
  logic [ADDR_W-1:0] c_bytes, c_next_incr;
  logic              hs, acc;

  assign acc = cmd_valid_i && cmd_ready_o;
  assign hs  = busy_o && beat_valid_i && beat_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sz_q <= '0;
      bt_q <= '0;
    end else if (acc) begin
      sz_q <= cmd_size_i;
      bt_q <= cmd_burst_i;
    end
  end

  always_comb begin
    c_bytes     = ADDR_W'(1) << sz_q;
    c_next_incr = (beat_addr_o & ~(c_bytes - ADDR_W'(1))) + c_bytes;
  end

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> busy_o && !cmd_ready_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !hs |=> busy_o && $stable(beat_addr_o) && $stable(beat_strb_o)
                      && $stable(beat_last_o));

  assert_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && beat_last_o |=> !busy_o && cmd_ready_o);

  assert_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !beat_last_o && bt_q == 2'd0 |=> beat_addr_o == $past(beat_addr_o));

  assert_incr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !beat_last_o && bt_q == 2'd1 |=> beat_addr_o == $past(c_next_incr));

  assert_lanes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> beat_strb_o != '0 && $countones(beat_strb_o) <= (32'd1 << sz_q));

  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> beat_strb_o == '0 && !beat_last_o);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .cmd_size_i  (cmd_size_i),
  .cmd_burst_i (cmd_burst_i),
  .beat_valid_i(beat_valid_i),
  .beat_ready_i(beat_ready_i),
  .busy_o      (busy_o),
  .beat_addr_o (beat_addr_o),
  .beat_strb_o (beat_strb_o),
  .beat_last_o (beat_last_o)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 32;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_len = '0;
  logic [2:0]    cmd_size = '0;
  logic [1:0]    cmd_burst = '0;
  logic          beat_valid = 1'b0;
  logic          beat_ready = 1'b0;
  logic          busy;
  logic [AW-1:0] beat_addr;
  logic [SW-1:0] beat_strb;
  logic          beat_last;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .DATA_W(64)) u_burst_addr_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len), .cmd_size_i(cmd_size),
    .cmd_burst_i(cmd_burst),
    .beat_valid_i(beat_valid), .beat_ready_i(beat_ready),
    .busy_o(busy), .beat_addr_o(beat_addr), .beat_strb_o(beat_strb),
    .beat_last_o(beat_last)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] st, input int sz,
                                             input int ln, input int bt, input int n);
    logic [AW-1:0] bytes, al, wl, bnd;
    bytes = AW'(1) << sz;
    al    = st & ~(bytes - 1);
    wl    = AW'(ln + 1) * bytes;
    bnd   = st & ~(wl - 1);
    case (bt)
      0:       return st;
      2:       return bnd + ((st - bnd + AW'(n) * bytes) & (wl - 1));
      default: return (n == 0) ? st : al + AW'(n) * bytes;
    endcase
  endfunction

  function automatic logic [SW-1:0] exp_strb(input logic [AW-1:0] a, input int sz);
    int lo, base, bytes;
    logic [SW-1:0] m;
    bytes = 1 << sz;
    lo    = int'(a % SW);
    base  = (lo / bytes) * bytes;
    m = '0;
    for (int i = 0; i < SW; i++) m[i] = (i >= lo) && (i < base + bytes);
    return m;
  endfunction

  task automatic run_burst(input logic [AW-1:0] st, input int ln, input int sz,
                           input int bt, input int stall_pct, input string req);
    logic [AW-1:0] ea;
    @(negedge clk);
    check("R2 ready when idle", AW'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_addr = st; cmd_len = 8'(ln);
    cmd_size = 3'(sz); cmd_burst = 2'(bt);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2 busy after accept", AW'(busy), 1);
    check("R2 ready low while busy", AW'(cmd_ready), 0);
    for (int n = 0; n <= ln; n++) begin
      while (($urandom % 100) < stall_pct) begin
        beat_valid = 1'($urandom);
        beat_ready = ~beat_valid;
        // stray command during the burst must be ignored (R2)
        cmd_valid = 1'b1; cmd_addr = $urandom; cmd_len = 8'($urandom);
        cmd_size = 3'($urandom % 4); cmd_burst = 2'($urandom % 3);
        @(negedge clk);
        cmd_valid = 1'b0; beat_valid = 1'b0; beat_ready = 1'b0;
      end
      ea = exp_addr(st, sz, ln, bt, n);
      check({req, " address"}, beat_addr, ea);
      check("R6 lane mask", AW'(beat_strb), AW'(exp_strb(ea, sz)));
      check("R7 last flag", AW'(beat_last), AW'(n == ln));
      beat_valid = 1'b1; beat_ready = 1'b1;
      @(negedge clk);
      beat_valid = 1'b0; beat_ready = 1'b0;
    end
    check("R7 idle after last beat", AW'(busy), 0);
    check("R7 last low when idle", AW'(beat_last), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    check("R1 reset busy", AW'(busy), 0);
    check("R1 reset ready", AW'(cmd_ready), 1);
    check("R1 reset strobe", AW'(beat_strb), 0);
    check("R1 reset last", AW'(beat_last), 0);
    #9 rst_n = 1'b1;

    // handshake while idle must do nothing (R2)
    @(negedge clk);
    beat_valid = 1'b1; beat_ready = 1'b1;
    @(negedge clk);
    beat_valid = 1'b0; beat_ready = 1'b0;
    check("R2 idle handshake ignored busy", AW'(busy), 0);
    check("R2 idle handshake ignored strobe", AW'(beat_strb), 0);

    run_burst(32'h0000_1005, 3, 1, 0, 30, "R3 fixed");
    run_burst(32'h0000_1006, 5, 2, 1, 30, "R4 incr unaligned");
    run_burst(32'h0000_0003, 9, 0, 1, 0, "R4 incr byte rotate");
    run_burst(32'h0000_010C, 3, 2, 2, 20, "R5 wrap4");
    run_burst(32'h0000_2038, 15, 3, 2, 10, "R5 wrap16");
    run_burst(32'h0000_0402, 1, 1, 2, 0, "R5 wrap2");
    run_burst(32'h0000_2000, 255, 3, 1, 5, "R7 incr 256 beats");

    for (int k = 0; k < 40; k++) begin
      int bt, sz, ln;
      logic [AW-1:0] st;
      bt = int'($urandom % 3);
      sz = int'($urandom % 4);
      st = $urandom & 32'h000F_FFFF;
      if (bt == 2) begin
        ln = (2 << ($urandom % 4)) - 1;
        st = st & ~((AW'(1) << sz) - 1);
      end else begin
        ln = int'($urandom % 32);
      end
      run_burst(st, ln, sz, bt, 25,
                bt == 0 ? "R3 random fixed" : (bt == 1 ? "R4 random incr" : "R5 random wrap"));
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule